// File: doc/BRIEF.md
# Edge/Level Interrupt Request Dispatcher

This block sits between a set of interrupt lines and the fabric that carries interrupt messages to processors. Line changes arrive as notices, one per cycle, each naming a pin and its new level. For every pin the block holds a routing entry (vector, destination, destination addressing mode, delivery mode, trigger kind, mask), a request bit, a remote-pending flag for level pins and a counter of back-to-back re-fires. Accepted interrupts are queued per pin and leave through a valid/ready message port, one per cycle, lowest pin first.

Edge pins fire once per request and fold repeats into a coalesced report. Level pins fire, then stay quiet until an end-of-interrupt (EOI) notice with a matching vector clears their remote-pending flag. If the line is still high at that point, the interrupt is sent again. A pin that keeps re-firing from EOIs is throttled: every STORM_LIMIT-th consecutive re-fire is not sent at once. Instead a timer of DEFER_CYCLES clock cycles starts, and when it runs out all level pins that still wait are swept and sent.

Top module: `irq_dispatch_core`

## Requirements
- R1: A notice with level 0 clears the pin's request bit and never causes a delivery. A later level-1 notice on an edge pin is then a fresh request and is not reported as coalesced.
- R2: On an edge pin, a level-1 notice that finds the request bit clear queues one delivery. A level-1 notice that finds it already set queues nothing and raises `ln_coalesced` for one cycle, in the cycle after the notice.
- R3: On a level pin whose remote-pending flag is set, a level-1 notice records the request, queues nothing and raises `ln_coalesced`.
- R4: A masked pin is never delivered, but its request bit is still recorded, so a second level-1 notice on a masked edge pin is coalesced. After reset every entry is masked and edge-triggered. A write that masks a pin drops any delivery still queued for it.
- R5: Queuing a delivery for a level pin sets its remote-pending flag.
- R6: An EOI with level flag 1, with directed mode inactive and with a vector equal to a level entry's vector clears that entry's remote-pending flag. If the pin is unmasked and its request bit is set, a delivery is queued at once. An EOI with another vector has no effect on the pin.
- R7: Each level pin counts consecutive EOI re-fires. The STORM_LIMIT-th one queues nothing: it resets the count and starts the deferral timer.
- R8: An EOI that matches a level pin that is masked or has its request clear resets that pin's re-fire count to zero.
- R9: DEFER_CYCLES cycles after the EOI that started the timer, every unmasked level pin whose request is set and whose remote-pending flag is clear gets a queued delivery.
- R10: An EOI with level flag 0, or one that arrives while `eoi_directed` is 1, leaves remote-pending set and queues nothing.
- R11: An entry write clears the pin's remote-pending flag. If the new entry is level-triggered and unmasked and the request bit is set, a delivery is queued.
- R12: When several pins are queued, the lowest index is offered first. An offer that is not taken stays valid until it is taken.
- R13: A delivery message carries the offered pin's current vector, destination, destination mode, delivery mode and trigger kind (1 = level).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ln_valid | input | 1 | Line-change notice present |
| ln_pin | input | PIN_W | Pin of the notice |
| ln_level | input | 1 | New line level |
| ln_coalesced | output | 1 | Previous cycle's notice was coalesced |
| cfg_wr_en | input | 1 | Write one routing entry |
| cfg_wr_pin | input | PIN_W | Entry index to write |
| cfg_vector | input | 8 | Vector field |
| cfg_dest | input | 8 | Destination field |
| cfg_dest_logical | input | 1 | Destination mode, 1 = logical |
| cfg_mode | input | 3 | Delivery mode |
| cfg_level_trig | input | 1 | 1 = level, 0 = edge |
| cfg_masked | input | 1 | 1 = masked |
| eoi_valid | input | 1 | EOI notice present |
| eoi_vector | input | 8 | Vector being acknowledged |
| eoi_level | input | 1 | EOI marked level-triggered |
| eoi_directed | input | 1 | Directed-EOI mode active, EOI does not clear flags |
| dlv_valid | output | 1 | Delivery message offered |
| dlv_ready | input | 1 | Receiver takes the message |
| dlv_pin | output | PIN_W | Pin being delivered |
| dlv_vector | output | 8 | Vector |
| dlv_dest | output | 8 | Destination |
| dlv_dest_logical | output | 1 | Destination mode |
| dlv_mode | output | 3 | Delivery mode |
| dlv_level_trig | output | 1 | Trigger kind |

## Verification
Every notice, write and EOI acts at the clock edge that samples it. A queued delivery is offered right after that edge, and `ln_coalesced` is registered at the same edge. The bench drives at the falling edge and checks at the next falling edge, one clock later. A deferred re-fire must stay absent for DEFER_CYCLES-1 falling-edge samples and then be present at the DEFER_CYCLES-th, so an off-by-one in the timer shows up. Offers are checked while `dlv_ready` is held low, so both ordering and hold behaviour are visible before the bench takes each message.

// File: rtl/ird_pkg.sv
package ird_pkg;
   localparam int IRD_VEC_W  = 8;
   localparam int IRD_DEST_W = 8;
   localparam int IRD_MODE_W = 3;

   typedef struct packed {
      logic [IRD_VEC_W-1:0]  vector;
      logic [IRD_DEST_W-1:0] dest;
      logic                  dest_logical;
      logic [IRD_MODE_W-1:0] mode;
      logic                  level_trig;
      logic                  masked;
   } ird_entry_t;

   localparam ird_entry_t IRD_ENTRY_RESET = '{
      vector: '0, dest: '0, dest_logical: 1'b0,
      mode: '0, level_trig: 1'b0, masked: 1'b1};
endpackage

// File: rtl/ird_pin_slice.sv
module ird_pin_slice
   import ird_pkg::*;
#(
   parameter int STORM_LIMIT = 10000,
   localparam int CNT_W = (STORM_LIMIT > 2) ? $clog2(STORM_LIMIT) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_hit,
   input  ird_entry_t           wr_entry,
   input  logic                 ln_hit,
   input  logic                 ln_level,
   input  logic                 eoi_valid,
   input  logic [IRD_VEC_W-1:0] eoi_vector,
   input  logic                 eoi_level,
   input  logic                 eoi_directed,
   input  logic                 scan_fire,
   output ird_entry_t           entry_q,
   output logic                 remote_q,
   output logic                 svc_set,
   output logic                 svc_clr,
   output logic                 coal,
   output logic                 defer_req
);
   logic             req_q;
   logic [CNT_W-1:0] cnt_q;

   ird_entry_t       e_n;
   logic             irr_n, rem_n;
   logic [CNT_W-1:0] cnt_n;

   // Events applied in a fixed order: write, line notice, EOI, sweep.
   always_comb begin
      e_n       = entry_q;
      irr_n     = req_q;
      rem_n     = remote_q;
      cnt_n     = cnt_q;
      svc_set   = 1'b0;
      svc_clr   = 1'b0;
      coal      = 1'b0;
      defer_req = 1'b0;

      if (wr_hit) begin
         e_n   = wr_entry;
         rem_n = 1'b0;
         if (e_n.masked) begin
            svc_clr = 1'b1;
         end else if (e_n.level_trig && irr_n) begin
            svc_set = 1'b1;
            rem_n   = 1'b1;
         end
      end

      if (ln_hit) begin
         if (!ln_level) begin
            irr_n = 1'b0;
         end else if (!e_n.level_trig && irr_n) begin
            coal = 1'b1;
         end else begin
            irr_n = 1'b1;
            if (e_n.level_trig && rem_n) begin
               coal = 1'b1;
            end else if (!e_n.masked) begin
               svc_set = 1'b1;
               if (e_n.level_trig) rem_n = 1'b1;
            end
         end
      end

      if (eoi_valid && eoi_level && !eoi_directed && e_n.level_trig &&
          (e_n.vector == eoi_vector)) begin
         rem_n = 1'b0;
         if (!e_n.masked && irr_n) begin
            if (cnt_n == CNT_W'(STORM_LIMIT - 1)) begin
               cnt_n     = '0;
               defer_req = 1'b1;
            end else begin
               cnt_n   = cnt_n + 1'b1;
               svc_set = 1'b1;
               rem_n   = 1'b1;
            end
         end else begin
            cnt_n = '0;
         end
      end

      if (scan_fire && e_n.level_trig && irr_n && !rem_n && !e_n.masked) begin
         svc_set = 1'b1;
         rem_n   = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         entry_q  <= IRD_ENTRY_RESET;
         req_q    <= 1'b0;
         remote_q <= 1'b0;
         cnt_q    <= '0;
      end else begin
         entry_q  <= e_n;
         req_q    <= irr_n;
         remote_q <= rem_n;
         cnt_q    <= cnt_n;
      end
   end
endmodule

// File: rtl/ird_defer_timer.sv
module ird_defer_timer #(
   parameter int DEFER_CYCLES = 100000,
   localparam int TW = $clog2(DEFER_CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic fire
);
   logic          busy_q;
   logic [TW-1:0] cnt_q;

   assign fire = busy_q && (cnt_q == TW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (fire) begin
         busy_q <= 1'b0;
      end else if (busy_q) begin
         cnt_q <= cnt_q - 1'b1;
      end else if (start) begin
         busy_q <= 1'b1;
         cnt_q  <= TW'(DEFER_CYCLES);
      end
   end
endmodule

// File: rtl/ird_pick_lowest.sv
module ird_pick_lowest #(
   parameter int N = 24,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [N-1:0]  grant,
   output logic [IW-1:0] idx
);
   assign any = |req;

   always_comb begin
      grant = '0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            grant    = '0;
            grant[i] = 1'b1;
            idx      = IW'(i);
         end
      end
   end
endmodule

// File: rtl/irq_dispatch_core.sv
module irq_dispatch_core
   import ird_pkg::*;
#(
   parameter int NUM_PINS     = 24,
   parameter int STORM_LIMIT  = 10000,
   parameter int DEFER_CYCLES = 100000,
   localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ln_valid,
   input  logic [PIN_W-1:0]      ln_pin,
   input  logic                  ln_level,
   output logic                  ln_coalesced,
   input  logic                  cfg_wr_en,
   input  logic [PIN_W-1:0]      cfg_wr_pin,
   input  logic [IRD_VEC_W-1:0]  cfg_vector,
   input  logic [IRD_DEST_W-1:0] cfg_dest,
   input  logic                  cfg_dest_logical,
   input  logic [IRD_MODE_W-1:0] cfg_mode,
   input  logic                  cfg_level_trig,
   input  logic                  cfg_masked,
   input  logic                  eoi_valid,
   input  logic [IRD_VEC_W-1:0]  eoi_vector,
   input  logic                  eoi_level,
   input  logic                  eoi_directed,
   output logic                  dlv_valid,
   input  logic                  dlv_ready,
   output logic [PIN_W-1:0]      dlv_pin,
   output logic [IRD_VEC_W-1:0]  dlv_vector,
   output logic [IRD_DEST_W-1:0] dlv_dest,
   output logic                  dlv_dest_logical,
   output logic [IRD_MODE_W-1:0] dlv_mode,
   output logic                  dlv_level_trig
);
   if (NUM_PINS < 2) begin : g_bad_pins
      $error("irq_dispatch_core: NUM_PINS must be at least 2");
   end
   if (STORM_LIMIT < 2) begin : g_bad_storm
      $error("irq_dispatch_core: STORM_LIMIT must be at least 2");
   end
   if (DEFER_CYCLES < 1) begin : g_bad_defer
      $error("irq_dispatch_core: DEFER_CYCLES must be at least 1");
   end

   ird_entry_t          wr_entry;
   ird_entry_t          ent_arr [NUM_PINS];
   logic [NUM_PINS-1:0] rem_vec, mask_vec, level_vec;
   logic [NUM_PINS-1:0] svc_set, svc_clr, coal_vec, defer_vec;
   logic [NUM_PINS-1:0] q_pend, grant, take_vec;
   logic                defer_fire;

   assign wr_entry = '{vector: cfg_vector, dest: cfg_dest,
                       dest_logical: cfg_dest_logical, mode: cfg_mode,
                       level_trig: cfg_level_trig, masked: cfg_masked};

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      ird_pin_slice #(.STORM_LIMIT(STORM_LIMIT)) u_slice (
         .clk          (clk),
         .rst_n        (rst_n),
         .wr_hit       (cfg_wr_en && (cfg_wr_pin == PIN_W'(i))),
         .wr_entry     (wr_entry),
         .ln_hit       (ln_valid && (ln_pin == PIN_W'(i))),
         .ln_level     (ln_level),
         .eoi_valid    (eoi_valid),
         .eoi_vector   (eoi_vector),
         .eoi_level    (eoi_level),
         .eoi_directed (eoi_directed),
         .scan_fire    (defer_fire),
         .entry_q      (ent_arr[i]),
         .remote_q     (rem_vec[i]),
         .svc_set      (svc_set[i]),
         .svc_clr      (svc_clr[i]),
         .coal         (coal_vec[i]),
         .defer_req    (defer_vec[i])
      );
      assign mask_vec[i]  = ent_arr[i].masked;
      assign level_vec[i] = ent_arr[i].level_trig;
   end

   ird_defer_timer #(.DEFER_CYCLES(DEFER_CYCLES)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (|defer_vec),
      .fire  (defer_fire)
   );

   ird_pick_lowest #(.N(NUM_PINS)) u_pick (
      .req   (q_pend),
      .any   (dlv_valid),
      .grant (grant),
      .idx   (dlv_pin)
   );

   assign take_vec = grant & {NUM_PINS{dlv_valid & dlv_ready}};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_pend       <= '0;
         ln_coalesced <= 1'b0;
      end else begin
         q_pend       <= (q_pend & ~take_vec & ~svc_clr) | svc_set;
         ln_coalesced <= |coal_vec;
      end
   end

   assign dlv_vector       = ent_arr[dlv_pin].vector;
   assign dlv_dest         = ent_arr[dlv_pin].dest;
   assign dlv_dest_logical = ent_arr[dlv_pin].dest_logical;
   assign dlv_mode         = ent_arr[dlv_pin].mode;
   assign dlv_level_trig   = ent_arr[dlv_pin].level_trig;
endmodule

// File: rtl/irq_dispatch_core_chk.sv
module irq_dispatch_core_chk #(
   parameter int NUM_PINS = 24,
   localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                ln_valid,
   input logic [PIN_W-1:0]    ln_pin,
   input logic                ln_level,
   input logic                ln_coalesced,
   input logic                cfg_wr_en,
   input logic                eoi_valid,
   input logic                dlv_valid,
   input logic                dlv_ready,
   input logic [PIN_W-1:0]    dlv_pin,
   input logic [NUM_PINS-1:0] q_pend,
   input logic [NUM_PINS-1:0] mask_vec,
   input logic [NUM_PINS-1:0] level_vec,
   input logic [NUM_PINS-1:0] rem_vec,
   input logic                defer_fire
);
   a_r4_masked_never_offered: assert property (@(posedge clk) disable iff (!rst_n)
      dlv_valid |-> !mask_vec[dlv_pin]);

   a_r12_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
      dlv_valid |-> ((q_pend & ((NUM_PINS'(1) << dlv_pin) - NUM_PINS'(1))) == '0));

   a_r12_offer_held: assert property (@(posedge clk) disable iff (!rst_n)
      dlv_valid && !dlv_ready && !cfg_wr_en |=> dlv_valid);

   a_r2_coal_after_assert: assert property (@(posedge clk) disable iff (!rst_n)
      ln_coalesced |-> $past(ln_valid && ln_level));

   a_r9_fire_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      defer_fire |=> !defer_fire);

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin_chk
      a_r1_low_queues_nothing: assert property (@(posedge clk) disable iff (!rst_n)
         ln_valid && (ln_pin == PIN_W'(i)) && !ln_level && !cfg_wr_en &&
         !eoi_valid && !defer_fire |=> !$rose(q_pend[i]));

      a_r5_level_queue_sets_remote: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(q_pend[i]) && level_vec[i] |-> rem_vec[i]);
   end
endmodule

bind irq_dispatch_core irq_dispatch_core_chk #(.NUM_PINS(NUM_PINS)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ln_valid     (ln_valid),
   .ln_pin       (ln_pin),
   .ln_level     (ln_level),
   .ln_coalesced (ln_coalesced),
   .cfg_wr_en    (cfg_wr_en),
   .eoi_valid    (eoi_valid),
   .dlv_valid    (dlv_valid),
   .dlv_ready    (dlv_ready),
   .dlv_pin      (dlv_pin),
   .q_pend       (q_pend),
   .mask_vec     (mask_vec),
   .level_vec    (level_vec),
   .rem_vec      (rem_vec),
   .defer_fire   (defer_fire)
);

// File: tb/test_irq_dispatch_core.sv
`timescale 1ns/1ps
module test_irq_dispatch_core;
   localparam int NP = 4;
   localparam int SL = 3;
   localparam int DC = 12;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ln_valid = 1'b0, ln_level = 1'b0;
   logic [1:0] ln_pin = '0;
   logic       ln_coalesced;
   logic       cfg_wr_en = 1'b0, cfg_dest_logical = 1'b0, cfg_level_trig = 1'b0, cfg_masked = 1'b0;
   logic [1:0] cfg_wr_pin = '0;
   logic [7:0] cfg_vector = '0, cfg_dest = '0;
   logic [2:0] cfg_mode = '0;
   logic       eoi_valid = 1'b0, eoi_level = 1'b0, eoi_directed = 1'b0;
   logic [7:0] eoi_vector = '0;
   logic       dlv_valid, dlv_ready = 1'b0;
   logic [1:0] dlv_pin;
   logic [7:0] dlv_vector, dlv_dest;
   logic       dlv_dest_logical, dlv_level_trig;
   logic [2:0] dlv_mode;

   int  n_checks = 0;
   int  n_fails  = 0;
   bit  done     = 1'b0;

   int exp_vec [NP];
   int exp_dest[NP];
   int exp_log [NP];
   int exp_mode[NP];
   int exp_lvl [NP];

   always #2 clk = ~clk;

   irq_dispatch_core #(.NUM_PINS(NP), .STORM_LIMIT(SL), .DEFER_CYCLES(DC)) i_irq_dispatch_core (
      .clk(clk), .rst_n(rst_n),
      .ln_valid(ln_valid), .ln_pin(ln_pin), .ln_level(ln_level), .ln_coalesced(ln_coalesced),
      .cfg_wr_en(cfg_wr_en), .cfg_wr_pin(cfg_wr_pin), .cfg_vector(cfg_vector), .cfg_dest(cfg_dest),
      .cfg_dest_logical(cfg_dest_logical), .cfg_mode(cfg_mode), .cfg_level_trig(cfg_level_trig),
      .cfg_masked(cfg_masked),
      .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .eoi_level(eoi_level), .eoi_directed(eoi_directed),
      .dlv_valid(dlv_valid), .dlv_ready(dlv_ready), .dlv_pin(dlv_pin), .dlv_vector(dlv_vector),
      .dlv_dest(dlv_dest), .dlv_dest_logical(dlv_dest_logical), .dlv_mode(dlv_mode),
      .dlv_level_trig(dlv_level_trig)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input int p, input int vec, input int dst, input int lg,
                     input int md, input int lvl, input int msk);
      cfg_wr_en = 1'b1; cfg_wr_pin = p[1:0]; cfg_vector = vec[7:0]; cfg_dest = dst[7:0];
      cfg_dest_logical = lg[0]; cfg_mode = md[2:0]; cfg_level_trig = lvl[0]; cfg_masked = msk[0];
      exp_vec[p] = vec; exp_dest[p] = dst; exp_log[p] = lg; exp_mode[p] = md; exp_lvl[p] = lvl;
      @(negedge clk);
      cfg_wr_en = 1'b0;
   endtask

   task automatic notice(input int p, input bit lvl, input bit exp_coal, input string req);
      ln_valid = 1'b1; ln_pin = p[1:0]; ln_level = lvl;
      @(negedge clk);
      ln_valid = 1'b0;
      check(ln_coalesced == exp_coal, req, int'(ln_coalesced), int'(exp_coal));
   endtask

   task automatic eoi(input int vec, input bit lvl, input bit dir);
      eoi_valid = 1'b1; eoi_vector = vec[7:0]; eoi_level = lvl; eoi_directed = dir;
      @(negedge clk);
      eoi_valid = 1'b0; eoi_directed = 1'b0;
   endtask

   task automatic idle(input string req);
      check(dlv_valid == 1'b0, req, int'(dlv_valid), 0);
   endtask

   task automatic offered(input int p, input string req);
      check(dlv_valid == 1'b1, req, int'(dlv_valid), 1);
      check(int'(dlv_pin) == p, req, int'(dlv_pin), p);
   endtask

   // Check the offer and its message fields (R13), then take it.
   task automatic take(input int p, input string req);
      offered(p, req);
      check(int'(dlv_vector) == exp_vec[p], "R13 vector", int'(dlv_vector), exp_vec[p]);
      check(int'(dlv_dest) == exp_dest[p], "R13 dest", int'(dlv_dest), exp_dest[p]);
      check(int'(dlv_dest_logical) == exp_log[p], "R13 dest mode", int'(dlv_dest_logical), exp_log[p]);
      check(int'(dlv_mode) == exp_mode[p], "R13 delivery mode", int'(dlv_mode), exp_mode[p]);
      check(int'(dlv_level_trig) == exp_lvl[p], "R13 trigger", int'(dlv_level_trig), exp_lvl[p]);
      dlv_ready = 1'b1;
      @(negedge clk);
      dlv_ready = 1'b0;
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      idle("R4 reset idle");
      check(ln_coalesced == 1'b0, "R4 reset coalesced", int'(ln_coalesced), 0);
      // Reset entries are masked: an asserted line is not delivered.
      notice(0, 1'b1, 1'b0, "R4 reset masked");
      idle("R4 reset masked no delivery");
      notice(0, 1'b0, 1'b0, "R1 clear");

      // Edge sweep over every pin.
      for (int p = 0; p < NP; p++) begin
         wr(p, 32 + p, p * 5 + 1, p % 2, p % 8, 0, 0);
         notice(p, 1'b1, 1'b0, "R2 fresh edge");
         take(p, "R2 edge delivered");
         idle("R2 single delivery");
         notice(p, 1'b1, 1'b1, "R2 repeat coalesced");
         idle("R2 repeat no delivery");
         notice(p, 1'b0, 1'b0, "R1 low not coalesced");
         idle("R1 low no delivery");
         notice(p, 1'b1, 1'b0, "R1 fresh after low");
         take(p, "R1 redelivered after low");
         notice(p, 1'b0, 1'b0, "R1 low");
      end

      // Masked edge pin keeps its request.
      wr(1, 49, 7, 0, 2, 0, 1);
      notice(1, 1'b1, 1'b0, "R4 masked first");
      idle("R4 masked no delivery");
      notice(1, 1'b1, 1'b1, "R4 masked request recorded");
      idle("R4 masked still idle");
      notice(1, 1'b0, 1'b0, "R1 masked low");

      // Level pin 2.
      wr(2, 64, 9, 1, 1, 1, 0);
      notice(2, 1'b1, 1'b0, "R5 level first");
      take(2, "R5 level delivered");
      notice(2, 1'b0, 1'b0, "R1 level low");
      idle("R1 level low idle");
      notice(2, 1'b1, 1'b1, "R3 held by remote");
      idle("R3 held no delivery");
      eoi(64, 1'b0, 1'b0);
      idle("R10 edge-marked EOI ignored");
      eoi(64, 1'b1, 1'b1);
      idle("R10 directed EOI ignored");
      eoi(64, 1'b1, 1'b0);
      take(2, "R6 EOI redelivery");
      eoi(65, 1'b1, 1'b0);
      idle("R6 other vector ignored");
      eoi(64, 1'b1, 1'b0);
      take(2, "R6 second redelivery");

      // Masked EOI resets the counter; rewrite services the pin.
      wr(2, 64, 9, 1, 1, 1, 1);
      idle("R11 masked rewrite idle");
      eoi(64, 1'b1, 1'b0);
      idle("R8 masked EOI idle");
      wr(2, 64, 9, 1, 1, 1, 0);
      take(2, "R11 rewrite services");
      eoi(64, 1'b1, 1'b0);
      take(2, "R8 count restarted 1");
      eoi(64, 1'b1, 1'b0);
      take(2, "R8 count restarted 2");
      eoi(64, 1'b1, 1'b0);
      for (int k = 1; k < DC; k++) begin
         @(negedge clk);
         idle("R7 deferred not yet");
      end
      @(negedge clk);
      take(2, "R9 deferred delivery");
      notice(2, 1'b0, 1'b0, "R1 level low");
      eoi(64, 1'b1, 1'b0);
      idle("R8 request clear EOI idle");

      // Two level pins sharing a vector.
      wr(0, 96, 3, 0, 5, 1, 0);
      wr(3, 96, 12, 1, 4, 1, 0);
      notice(3, 1'b1, 1'b0, "R12 pin3 asserts");
      notice(0, 1'b1, 1'b0, "R12 pin0 asserts");
      offered(0, "R12 lowest first");
      @(negedge clk);
      offered(0, "R12 held without ready");
      take(0, "R12 take pin0");
      take(3, "R12 take pin3");
      eoi(96, 1'b1, 1'b0);
      take(0, "R6 shared vector pin0");
      take(3, "R6 shared vector pin3");
      eoi(96, 1'b1, 1'b0);
      take(0, "R7 count 2 pin0");
      take(3, "R7 count 2 pin3");
      eoi(96, 1'b1, 1'b0);
      for (int k = 1; k < DC; k++) begin
         @(negedge clk);
         idle("R7 both deferred");
      end
      @(negedge clk);
      take(0, "R9 sweep pin0");
      take(3, "R9 sweep pin3");
      idle("R9 sweep done");

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog R1..all actual=running expected=finished");
         summary();
         $finish;
      end
   end
endmodule